// File: doc/BRIEF.md
# Dual-FIFO Cell Reassembly Reader

This block takes cells from two byte FIFOs, the network receive FIFO and the loopback FIFO, and rebuilds each cell's payload as 32-bit words in an SRAM cell buffer. Each FIFO entry is 9 bits wide: bits 7..0 carry data and bit 8 marks the first byte of a cell. While no cell is in progress, the reader takes bytes from whichever FIFO holds data. If both hold data, it alternates between them. A byte with the start flag set locks the reader onto that FIFO until the cell is complete. The flagged byte itself carries no payload and is dropped. Bytes that arrive while no cell is in progress and that carry no start flag are discarded.

Payload bytes are packed four to a word and written to consecutive word addresses, starting at a buffer base. The base is sampled from `buf_base` at the moment a cell is accepted, and a cell is accepted only when `buf_ok` shows that a buffer is free. If a second start flag arrives before the cell is complete, the partial cell is abandoned. The new cell is then written from the start of the same buffer, and a sticky flag records the event.

If no buffer is free when a cell starts on the receive FIFO, that cell is read out and thrown away, and a different sticky flag records the event. While no buffer is free, the loopback FIFO is not read, so its own back pressure keeps it safe.

Top module: `cell_rx_reader`

## Requirements
- R1: Out of reset, with both FIFOs empty, the block issues no FIFO read and no SRAM write, does not pulse `cell_done`, and holds both sticky flags low.
- R2: A FIFO read strobe is only issued in a cycle when that FIFO's empty flag is low.
- R3: Each read strobe lasts one cycle and is followed by a cycle with no read, and the two FIFOs are never read in the same cycle.
- R4: While no cell is in progress and both FIFOs are non-empty (with a buffer free), successive reads alternate between the two FIFOs.
- R5: The start byte (bit 8 set) stores nothing. Payload byte i of a cell goes to bits 8*(i mod 4)+7..8*(i mod 4) of word i/4, so the first byte of each group of four is the least significant.
- R6: Word k of an accepted cell is written to address base+k, where base is the value of `buf_base` in the cycle the start byte is read. A cell of LEN_B bytes (default 52) produces exactly LEN_B/4 writes.
- R7: `cell_done` pulses for one cycle together with the write of the cell's last word.
- R8: A start byte read in the middle of a cell abandons the partial cell. The following payload is written again from base+0 of the same buffer, with no completion pulse for the abandoned part, and `st_restart` is set and stays set.
- R9: A cell that starts on the receive FIFO while `buf_ok` is low is read to its end (LEN_B payload bytes) and produces no write and no completion pulse, and `st_drop` is set and stays set.
- R10: While `buf_ok` is low and no cell is in progress, the loopback FIFO is not read. Once a buffer is free, a waiting loopback cell is accepted normally.
- R11: Bytes without a start flag that are read while no cell is in progress produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 9 | Receive FIFO head entry; bit 8 is the start flag |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_rd | output | 1 | Receive FIFO read strobe; the head entry is consumed at this edge |
| lb_data | input | 9 | Loopback FIFO head entry; bit 8 is the start flag |
| lb_empty | input | 1 | Loopback FIFO empty |
| lb_rd | output | 1 | Loopback FIFO read strobe |
| buf_ok | input | 1 | A receive buffer is free |
| buf_base | input | AW | Word address of the free buffer |
| mem_we | output | 1 | SRAM word write strobe |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| cell_done | output | 1 | One-cycle pulse with the last word of a cell |
| st_restart | output | 1 | Sticky: a cell was cut short by a new start byte |
| st_drop | output | 1 | Sticky: a receive cell was discarded for lack of a buffer |

## Verification
Some properties are checked by assertions on every cycle. These are: reads happen only from a non-empty FIFO; the read strobe is a single cycle and only one FIFO is read at a time; every completion pulse comes with a write; both status flags stay set once set; no write appears while a cell is being dropped; and the loopback FIFO is read without a free buffer only inside an accepted cell. Other behaviour needs whole scenarios, so only the bench can show it. That covers the byte order inside a word, the address sequence from the sampled base, the rewrite from word zero after a restart, a full drain of a dropped receive cell while a loopback cell waits untouched, and the alternation pattern when both FIFOs hold data.

// File: rtl/cell_rx_pkg.sv
// Shared types for the dual-FIFO cell reassembly reader.
// Assumes: one payload byte per FIFO entry, four byte lanes per SRAM word.
package cell_rx_pkg;
    typedef enum logic [1:0] {
        M_HUNT = 2'd0,   // no cell in progress, looking for a start byte
        M_CELL = 2'd1,   // cell accepted, locked to one FIFO
        M_DROP = 2'd2    // receive cell being drained without a buffer
    } rx_mode_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned WORD_W = BYTE_W * LANES;
endpackage

// File: rtl/cell_rx_arb.sv
// FIFO read arbiter. Picks which FIFO to pop in the current cycle.
// Assumes: FIFO head data is valid whenever empty is low (first-word
// fall-through), and a strobe consumes the head at the rising edge.
// A read is always followed by an idle cycle, so every empty flag has
// settled before it is looked at again.
module cell_rx_arb
    import cell_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rx_mode_e mode,
    input  logic     lock_lb,
    input  logic     buf_ok,
    input  logic     rx_empty,
    input  logic     lb_empty,
    output logic     rx_rd,
    output logic     lb_rd
);
    logic gap_q;
    logic last_lb_q;
    logic rx_ok, lb_ok, lb_hunt_ok;

    // Choose the FIFO to read from the mode, the empty flags and the last source.
    always_comb begin
        rx_ok      = !rx_empty && !gap_q;
        lb_ok      = !lb_empty && !gap_q;
        lb_hunt_ok = lb_ok && buf_ok;
        rx_rd      = 1'b0;
        lb_rd      = 1'b0;
        unique case (mode)
            M_HUNT: begin
                if (rx_ok && lb_hunt_ok) begin
                    rx_rd = last_lb_q;
                    lb_rd = !last_lb_q;
                end else begin
                    rx_rd = rx_ok;
                    lb_rd = lb_hunt_ok && !rx_ok;
                end
            end
            M_CELL: begin
                rx_rd = rx_ok && !lock_lb;
                lb_rd = lb_ok && lock_lb;
            end
            default: rx_rd = rx_ok;
        endcase
    end

    // Insert the idle cycle after each read and remember the source just read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= 1'b0;
            last_lb_q <= 1'b1;
        end else begin
            gap_q <= rx_rd || lb_rd;
            if (rx_rd || lb_rd) begin
                last_lb_q <= lb_rd;
            end
        end
    end
endmodule

// File: rtl/cell_rx_ctrl.sv
// Cell sequencer. Tracks hunt / cell / drop mode, counts payload bytes and
// raises the load, rewind and push commands for the packer. Sets the sticky
// status flags.
// Assumes: a cell carries exactly LEN_B payload bytes after its start byte.
module cell_rx_ctrl
    import cell_rx_pkg::*;
#(
    parameter int unsigned LEN_B = 52
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_rd,
    input  logic     lb_rd,
    input  logic     soc,
    input  logic     buf_ok,
    output rx_mode_e mode,
    output logic     lock_lb,
    output logic     load,
    output logic     rewind,
    output logic     push,
    output logic     last,
    output logic     st_restart,
    output logic     st_drop
);
    localparam int unsigned CW = $clog2(LEN_B);

    logic          take;
    logic          at_end;
    logic          start_drop;
    logic [CW-1:0] cnt_q;

    // Decode the byte just taken into packer commands.
    always_comb begin
        take       = rx_rd || lb_rd;
        at_end     = (cnt_q == CW'(LEN_B - 1));
        load       = take && soc && buf_ok && (mode != M_CELL);
        start_drop = take && soc && !buf_ok && (mode != M_CELL);
        rewind     = take && soc && (mode == M_CELL);
        push       = take && !soc && (mode == M_CELL);
        last       = push && at_end;
    end

    // Mode, byte count and locked source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= M_HUNT;
            cnt_q   <= '0;
            lock_lb <= 1'b0;
        end else if (load) begin
            mode    <= M_CELL;
            cnt_q   <= '0;
            lock_lb <= lb_rd;
        end else if (start_drop || rewind) begin
            mode  <= start_drop ? M_DROP : M_CELL;
            cnt_q <= '0;
        end else if (take && !soc && (mode != M_HUNT)) begin
            cnt_q <= cnt_q + 1'b1;
            if (at_end) begin
                mode  <= M_HUNT;
                cnt_q <= '0;
            end
        end
    end

    // Sticky status flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_restart <= 1'b0;
            st_drop    <= 1'b0;
        end else begin
            if (rewind)     st_restart <= 1'b1;
            if (start_drop) st_drop    <= 1'b1;
        end
    end
endmodule

// File: rtl/cell_rx_pack.sv
// Byte-to-word packer and SRAM write port. Places byte lanes in
// little-endian order and writes each completed word to base plus word index.
// Assumes: LEN_B is a multiple of four, and load / rewind never coincide with push.
module cell_rx_pack
    import cell_rx_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned LEN_B = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rewind,
    input  logic              push,
    input  logic              last,
    input  logic [BYTE_W-1:0] din,
    input  logic [AW-1:0]     base_in,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              cell_done
);
    localparam int unsigned WORDS = LEN_B / LANES;
    localparam int unsigned WIW   = $clog2(WORDS + 1);
    localparam int unsigned LW    = $clog2(LANES);

    logic [AW-1:0]     base_q;
    logic [WIW-1:0]    widx_q;
    logic [LW-1:0]     lane_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] wnext;

    // Merge the incoming byte into its lane of the word being assembled.
    always_comb begin
        wnext = acc_q;
        wnext[{lane_q, 3'b000} +: BYTE_W] = din;
    end

    // Lane and word counters, base register and registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            widx_q    <= '0;
            lane_q    <= '0;
            acc_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cell_done <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            cell_done <= 1'b0;
            if (load || rewind) begin
                if (load) base_q <= base_in;
                widx_q <= '0;
                lane_q <= '0;
            end else if (push) begin
                acc_q  <= wnext;
                lane_q <= lane_q + 1'b1;
                if (lane_q == LW'(LANES - 1)) begin
                    mem_we    <= 1'b1;
                    mem_wdata <= wnext;
                    mem_addr  <= base_q + AW'(widx_q);
                    widx_q    <= widx_q + 1'b1;
                    cell_done <= last;
                end
            end
        end
    end
endmodule

// File: rtl/cell_rx_reader.sv
// Top of the dual-FIFO cell reassembly reader: the arbiter picks a FIFO,
// the sequencer tracks the cell and the packer writes the words.
// Assumes: FIFOs with fall-through heads and a word-addressed SRAM port
// that accepts a write in every cycle.
module cell_rx_reader
    import cell_rx_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned LEN_B = 52
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [8:0]    rx_data,
    input  logic          rx_empty,
    output logic          rx_rd,
    input  logic [8:0]    lb_data,
    input  logic          lb_empty,
    output logic          lb_rd,
    input  logic          buf_ok,
    input  logic [AW-1:0] buf_base,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          cell_done,
    output logic          st_restart,
    output logic          st_drop
);
    rx_mode_e   mode;
    logic       lock_lb;
    logic       load, rewind, push, last;
    logic [8:0] byte_sel;

    // Route the head entry of the FIFO being read.
    always_comb begin
        byte_sel = lb_rd ? lb_data : rx_data;
    end

    cell_rx_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .lock_lb  (lock_lb),
        .buf_ok   (buf_ok),
        .rx_empty (rx_empty),
        .lb_empty (lb_empty),
        .rx_rd    (rx_rd),
        .lb_rd    (lb_rd)
    );

    cell_rx_ctrl #(.LEN_B(LEN_B)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_rd      (rx_rd),
        .lb_rd      (lb_rd),
        .soc        (byte_sel[8]),
        .buf_ok     (buf_ok),
        .mode       (mode),
        .lock_lb    (lock_lb),
        .load       (load),
        .rewind     (rewind),
        .push       (push),
        .last       (last),
        .st_restart (st_restart),
        .st_drop    (st_drop)
    );

    cell_rx_pack #(.AW(AW), .LEN_B(LEN_B)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .rewind    (rewind),
        .push      (push),
        .last      (last),
        .din       (byte_sel[7:0]),
        .base_in   (buf_base),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cell_done (cell_done)
    );
endmodule

// File: rtl/cell_rx_reader_chk.sv
// Assertion checker for cell_rx_reader, attached by bind. It watches
// the ports and the sequencer mode.
module cell_rx_reader_chk
    import cell_rx_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     rx_empty,
    input logic     lb_empty,
    input logic     rx_rd,
    input logic     lb_rd,
    input logic     buf_ok,
    input logic     mem_we,
    input logic     cell_done,
    input logic     st_restart,
    input logic     st_drop,
    input rx_mode_e mode
);
    a_r2_rx_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> !rx_empty);
    a_r2_lb_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rd |-> !lb_empty);
    a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_rd && lb_rd));
    a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd || lb_rd) |=> !(rx_rd || lb_rd));
    a_r7_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done |-> mem_we);
    a_r8_restart_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_restart |=> st_restart);
    a_r9_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_drop |=> st_drop);
    a_r9_no_write_in_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_DROP) |-> !mem_we);
    a_r10_lb_needs_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_rd && !buf_ok) |-> (mode == M_CELL));
endmodule

bind cell_rx_reader cell_rx_reader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_empty   (rx_empty),
    .lb_empty   (lb_empty),
    .rx_rd      (rx_rd),
    .lb_rd      (lb_rd),
    .buf_ok     (buf_ok),
    .mem_we     (mem_we),
    .cell_done  (cell_done),
    .st_restart (st_restart),
    .st_drop    (st_drop),
    .mode       (mode)
);

// File: tb/sim_cell_rx_reader.sv
// Bench for cell_rx_reader: FIFO models built on queues, an SRAM model on
// an associative array, directed corner cases, then random cells.
module sim_cell_rx_reader;
    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int LEN_B = 52;
    localparam int WORDS = LEN_B / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8:0]    rx_data = '0, lb_data = '0;
    logic          rx_empty = 1'b1, lb_empty = 1'b1;
    logic          rx_rd, lb_rd;
    logic          buf_ok = 1'b1;
    logic [AW-1:0] buf_base = '0;
    logic          mem_we, cell_done, st_restart, st_drop;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;

    int checks = 0, fails = 0, cycles = 0, nwr = 0, ndone = 0;
    logic [8:0]  rxq[$], lbq[$];
    logic [31:0] mem[int];
    logic [7:0]  pay[LEN_B];
    int          rdlog[$];

    always #(CLK_P/2) clk = ~clk;

    cell_rx_reader #(.AW(AW), .LEN_B(LEN_B)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_data(rx_data), .rx_empty(rx_empty), .rx_rd(rx_rd),
        .lb_data(lb_data), .lb_empty(lb_empty), .lb_rd(lb_rd),
        .buf_ok(buf_ok), .buf_base(buf_base),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cell_done(cell_done), .st_restart(st_restart), .st_drop(st_drop)
    );

    // FIFO models: pop on a strobe, present the new head after the edge.
    always @(posedge clk) begin
        if (rx_rd && rxq.size() > 0) void'(rxq.pop_front());
        if (lb_rd && lbq.size() > 0) void'(lbq.pop_front());
        rx_empty <= (rxq.size() == 0);
        lb_empty <= (lbq.size() == 0);
        rx_data  <= (rxq.size() > 0) ? rxq[0] : 9'h0;
        lb_data  <= (lbq.size() > 0) ? lbq[0] : 9'h0;
    end

    // SRAM model and event log, sampled away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin mem[int'(mem_addr)] = mem_wdata; nwr++; end
            if (cell_done) ndone++;
            if (rx_rd) rdlog.push_back(0);
            if (lb_rd) rdlog.push_back(1);
        end
    end

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k);
        return {pay[4*k+3], pay[4*k+2], pay[4*k+1], pay[4*k]};
    endfunction

    task automatic new_payload();
        for (int i = 0; i < LEN_B; i++) pay[i] = 8'($urandom());
    endtask

    task automatic push_cell(input bit to_lb, input int gap_max);
        for (int i = 0; i <= LEN_B; i++) begin
            logic [8:0] e;
            e = (i == 0) ? {1'b1, 8'($urandom())} : {1'b0, pay[i-1]};
            if (to_lb) lbq.push_back(e); else rxq.push_back(e);
            if (gap_max > 0) repeat ($urandom_range(gap_max)) @(negedge clk);
        end
    endtask

    task automatic wait_done(input int target);
        for (int t = 0; t < 3000 && ndone < target; t++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic int cell_mismatch(input int base);
        int bad = 0;
        for (int k = 0; k < WORDS; k++)
            if (!mem.exists(base + k) || mem[base + k] !== exp_word(k)) bad++;
        return bad;
    endfunction

    initial begin
        int w0, d0, bad, base;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1: idle after reset
        check(!mem_we && !cell_done && !rx_rd && !lb_rd, "R1 idle outputs",
              {mem_we, cell_done, rx_rd, lb_rd}, 0);
        check(!st_restart && !st_drop, "R1 status clear", {st_drop, st_restart}, 0);

        // R5 R6 R7: one receive cell
        new_payload(); base = 16'h0100; buf_base = AW'(base);
        w0 = nwr; d0 = ndone;
        push_cell(1'b0, 0);
        wait_done(d0 + 1);
        bad = cell_mismatch(base);
        check(bad == 0, "R5 little-endian packing", bad, 0);
        check(mem[base] === {pay[3], pay[2], pay[1], pay[0]}, "R5 word0 lanes", mem[base], exp_word(0));
        check(nwr - w0 == WORDS, "R6 write count", nwr - w0, WORDS);
        check(ndone - d0 == 1, "R7 one completion pulse", ndone - d0, 1);

        // R4 R11: stray bytes in both FIFOs while hunting
        rdlog.delete(); w0 = nwr;
        for (int i = 0; i < 6; i++) begin
            rxq.push_back({1'b0, 8'($urandom())});
            lbq.push_back({1'b0, 8'($urandom())});
        end
        repeat (60) @(negedge clk);
        bad = 0;
        for (int i = 1; i < rdlog.size(); i++) if (rdlog[i] == rdlog[i-1]) bad++;
        check(rdlog.size() == 12 && bad == 0, "R4 alternating reads", bad, 0);
        check(nwr == w0, "R11 stray bytes not written", nwr - w0, 0);

        // R8: restart in the middle of a cell
        base = 16'h0200; buf_base = AW'(base);
        w0 = nwr; d0 = ndone;
        rxq.push_back(9'h1AA);
        for (int i = 0; i < 10; i++) rxq.push_back({1'b0, 8'($urandom())});
        new_payload();
        push_cell(1'b0, 0);
        wait_done(d0 + 1);
        check(cell_mismatch(base) == 0, "R8 rewritten from base", cell_mismatch(base), 0);
        check(nwr - w0 == 2 + WORDS, "R8 write count", nwr - w0, 2 + WORDS);
        check(ndone - d0 == 1, "R8 single completion", ndone - d0, 1);
        check(st_restart && !st_drop, "R8 restart flag", {st_drop, st_restart}, 1);

        // R9 R10: no buffer free
        buf_ok = 1'b0; w0 = nwr; d0 = ndone;
        new_payload(); push_cell(1'b0, 0);
        new_payload(); push_cell(1'b1, 0);
        for (int t = 0; t < 500 && rxq.size() > 0; t++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(rxq.size() == 0, "R9 receive cell drained", rxq.size(), 0);
        check(nwr == w0 && ndone == d0, "R9 nothing written", nwr - w0, 0);
        check(st_drop, "R9 drop flag", st_drop, 1);
        check(lbq.size() == LEN_B + 1, "R10 loopback untouched", lbq.size(), LEN_B + 1);
        base = 16'h0300; buf_base = AW'(base); buf_ok = 1'b1;
        wait_done(d0 + 1);
        check(cell_mismatch(base) == 0, "R10 loopback cell after buffer", cell_mismatch(base), 0);
        check(st_restart && st_drop, "R8 R9 flags stay set", {st_drop, st_restart}, 3);

        // R5 R6 R7: random cells from random FIFOs with stalls
        for (int c = 0; c < 16; c++) begin
            base = int'($urandom_range(16'hF000)) & ~32'h3;
            buf_base = AW'(base); w0 = nwr; d0 = ndone;
            new_payload();
            push_cell(1'($urandom()), 2);
            wait_done(d0 + 1);
            bad = cell_mismatch(base);
            check(bad == 0 && nwr - w0 == WORDS && ndone - d0 == 1,
                  "R6 random cell words", bad, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule